// File: doc/BRIEF.md
# Effective-Address Generator with Accumulator Load

This block takes the first word of a memory-reference instruction for a 16-bit accumulator machine, together with the address of that instruction and three index registers. From these it forms the effective address of the operand. Short instructions carry an 8-bit signed displacement. That displacement is added to the next sequential instruction address or to a selected index register. Long instructions fetch a second word that holds a full 16-bit address. That word is used as is, or offset by an index register, and it can go through one level of indirection through memory.

Once the address is known, the block carries out the load-accumulator operation. It reads the word at the effective address into its accumulator register and pulses a completion strobe. All memory traffic uses a single read-only request/ready port. Words whose opcode is not the load opcode are not accepted.

Top module: `ea_load_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, `acc_out` and `ea` are 0 and `done` and `mem_req` are low.
- R2: A `start` whose word has bits [15:11] other than 5'b11000 is ignored: no memory request is made, `done` stays low and `acc_out` keeps its value.
- R3: Short format (bit [10] = 0) with tag bits [9:8] = 0 gives an effective address of `instr_addr` + 1 + the sign-extended bits [7:0], with the sum taken modulo 2^16.
- R4: Short format with tag 1, 2 or 3 gives `xr1`, `xr2` or `xr3` plus the sign-extended bits [7:0], modulo 2^16.
- R5: Long format (bit [10] = 1) makes one read at `instr_addr` + 1. The word read there is the address (tag 0), or the address plus the selected index register modulo 2^16 (tag 1 to 3).
- R6: In long format, bit [7] = 1 adds one more read at the address from R5, and the word returned becomes the effective address. In short format, bit [7] is only part of the displacement.
- R7: The word read at the effective address appears on `acc_out` in the same cycle that `done` is high. `done` lasts exactly one cycle, and `acc_out` changes at no other time.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` stays unchanged. The port only reads.
- R9: `start` is ignored while an operation is in progress, and `mem_req` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Accept `instr_word` when idle |
| instr_word | input | 16 | First instruction word |
| instr_addr | input | 16 | Address of that instruction word |
| xr1 | input | 16 | Index register 1 |
| xr2 | input | 16 | Index register 2 |
| xr3 | input | 16 | Index register 3 |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| ea | output | 16 | Effective address, final when `done` |
| acc_out | output | 16 | Accumulator |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions watch, on every cycle, the handshake discipline: a pending request holds its address. They also check that the completion strobe is a single cycle, that no request is made while it is high, that the accumulator changes only together with the strobe, and that the address is steady at completion.

Only the bench's scenarios can show that the address arithmetic is right. That covers every format, tag and indirection combination, the wrap of sums and displacements, the number of reads made, and the rejection of foreign opcodes and of starts that arrive while busy.

// File: rtl/ea_load_pkg.sv
// Shared types for the effective-address/load unit.
// Assumes a 16-bit instruction word, opcode in the top five bits.
package ea_load_pkg;
    localparam int unsigned OPC_W = 5;
    localparam logic [OPC_W-1:0] OPC_LOAD = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH2,
        ST_INDIR,
        ST_READ,
        ST_DONE
    } ea_state_t;

    // Field layout of the first instruction word, MSB first.
    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic             long_fmt;
        logic [1:0]       tag;
        logic             ind;
        logic [6:0]       disp_low;
    } ea_word1_t;
endpackage

// File: rtl/ea_field_decode.sv
// Splits the first instruction word into opcode check, format, tag,
// indirect flag and sign-extended displacement. Purely combinational.
// Assumes W >= 16 and the layout held in ea_load_pkg::ea_word1_t.
module ea_field_decode
    import ea_load_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned DISP_W = 8
) (
    input  logic [15:0]  word,
    output logic         is_load,
    output logic         long_fmt,
    output logic [1:0]   tag,
    output logic         ind,
    output logic [W-1:0] disp_ext
);
    localparam int unsigned EXT_W = W - DISP_W;

    ea_word1_t f;
    logic [DISP_W-1:0] disp;

    // Field extraction and displacement sign extension.
    always_comb begin
        f        = ea_word1_t'(word);
        disp     = word[DISP_W-1:0];
        is_load  = (f.opc == OPC_LOAD);
        long_fmt = f.long_fmt;
        tag      = f.tag;
        ind      = f.ind;
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end
endmodule

// File: rtl/ea_index_sel.sv
// Picks the base operand of the address sum: an index register for a
// nonzero tag; otherwise next-instruction address (short) or zero (long).
// Assumes exactly three index registers selected by a 2-bit tag.
module ea_index_sel #(
    parameter int unsigned W      = 16,
    parameter int unsigned NUM_XR = 3
) (
    input  logic [1:0]              tag,
    input  logic                    long_fmt,
    input  logic [W-1:0]            instr_addr,
    input  logic [NUM_XR-1:0][W-1:0] xr,
    output logic [W-1:0]            base
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] xr_pick [NUM_XR+1];

    // Entry 0 is the untagged default, entries 1..NUM_XR the index registers.
    assign xr_pick[0] = long_fmt ? '0 : (instr_addr + ONE);
    generate
        for (genvar i = 1; i <= NUM_XR; i++) begin : g_xr
            assign xr_pick[i] = xr[i-1];
        end
    endgenerate

    // Tag-driven operand select.
    always_comb begin
        base = xr_pick[0];
        for (int k = 1; k <= NUM_XR; k++) begin
            if (int'(tag) == k) base = xr_pick[k];
        end
    end
endmodule

// File: rtl/ea_seq.sv
// Sequencer: holds the instruction context, runs the second-word fetch,
// optional indirect read and operand read over a request/ready port,
// and loads the accumulator. Assumes mem_rdata is valid with mem_ready.
module ea_seq
    import ea_load_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_load,
    input  logic         long_fmt,
    input  logic         ind,
    input  logic [W-1:0] base_live,
    input  logic [W-1:0] disp_live,
    input  logic [W-1:0] instr_addr,
    input  logic         mem_ready,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] ea,
    output logic [W-1:0] acc,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    ea_state_t    state_q;
    logic         ind_q;
    logic [W-1:0] base_q;
    logic [W-1:0] fetch_addr_q;
    logic [W-1:0] ea_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] sum;

    // Single shared adder: short EA while idle, long EA after the fetch.
    always_comb begin
        if (state_q == ST_FETCH2) sum = base_q + mem_rdata;
        else                      sum = base_live + disp_live;
    end

    // Memory request and address for the active access.
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = ea_q;
        unique case (state_q)
            ST_FETCH2: begin mem_req = 1'b1; mem_addr = fetch_addr_q; end
            ST_INDIR:  mem_req = 1'b1;
            ST_READ:   mem_req = 1'b1;
            default:   mem_req = 1'b0;
        endcase
    end

    // State machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ind_q        <= 1'b0;
            base_q       <= '0;
            fetch_addr_q <= '0;
            ea_q         <= '0;
            acc_q        <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start && is_load) begin
                        ind_q        <= ind;
                        base_q       <= base_live;
                        fetch_addr_q <= instr_addr + ONE;
                        if (long_fmt) begin
                            state_q <= ST_FETCH2;
                        end else begin
                            ea_q    <= sum;
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_FETCH2: begin
                    if (mem_ready) begin
                        ea_q    <= sum;
                        state_q <= ind_q ? ST_INDIR : ST_READ;
                    end
                end
                ST_INDIR: begin
                    if (mem_ready) begin
                        ea_q    <= mem_rdata;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        acc_q   <= mem_rdata;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ea   = ea_q;
    assign acc  = acc_q;
    assign done = (state_q == ST_DONE);
endmodule

// File: rtl/ea_load_unit.sv
// Top of the effective-address generator with accumulator load.
// Decodes the presented word, selects the base operand and drives the
// sequencer. Assumes instr_word/instr_addr/xr* are valid with start.
module ea_load_unit
    import ea_load_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned DISP_W = 8,
    parameter int unsigned NUM_XR = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [15:0]  instr_word,
    input  logic [W-1:0] instr_addr,
    input  logic [W-1:0] xr1,
    input  logic [W-1:0] xr2,
    input  logic [W-1:0] xr3,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_ready,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] ea,
    output logic [W-1:0] acc_out,
    output logic         done
);
    logic         is_load;
    logic         long_fmt;
    logic [1:0]   tag;
    logic         ind;
    logic [W-1:0] disp_ext;
    logic [W-1:0] base_live;
    logic [NUM_XR-1:0][W-1:0] xr_bus;

    // Pack index registers for the selector.
    assign xr_bus = {xr3, xr2, xr1};

    ea_field_decode #(.W(W), .DISP_W(DISP_W)) u_dec (
        .word     (instr_word),
        .is_load  (is_load),
        .long_fmt (long_fmt),
        .tag      (tag),
        .ind      (ind),
        .disp_ext (disp_ext)
    );

    ea_index_sel #(.W(W), .NUM_XR(NUM_XR)) u_sel (
        .tag        (tag),
        .long_fmt   (long_fmt),
        .instr_addr (instr_addr),
        .xr         (xr_bus),
        .base       (base_live)
    );

    ea_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_load    (is_load),
        .long_fmt   (long_fmt),
        .ind        (ind),
        .base_live  (base_live),
        .disp_live  (disp_ext),
        .instr_addr (instr_addr),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .ea         (ea),
        .acc        (acc_out),
        .done       (done)
    );
endmodule

// File: rtl/ea_load_unit_chk.sv
// Port-level protocol checker for ea_load_unit, attached by bind.
module ea_load_unit_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mem_req,
    input logic [W-1:0] mem_addr,
    input logic         mem_ready,
    input logic [W-1:0] ea,
    input logic [W-1:0] acc_out,
    input logic         done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_ACC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> done); // R7
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R9
    AST_EA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $stable(ea)); // R7
endmodule

bind ea_load_unit ea_load_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .ea        (ea),
    .acc_out   (acc_out),
    .done      (done)
);

// File: tb/ea_load_unit_tb.sv
// Vector-table bench with a behavioural memory and directed corner tests.
module ea_load_unit_tb;
    localparam logic [15:0] XR1_V = 16'h1000;
    localparam logic [15:0] XR2_V = 16'hFFF0;
    localparam logic [15:0] XR3_V = 16'h8001;
    localparam int NVEC = 11;
    // {first word, instruction address, second word, latency}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'hC005, 16'h0100, 16'h0000, 16'd0},
        {16'hC0FE, 16'h0100, 16'h0000, 16'd1},
        {16'hC110, 16'h0300, 16'h0000, 16'd2},
        {16'hC220, 16'h0300, 16'h0000, 16'd0},
        {16'hC380, 16'h0300, 16'h0000, 16'd3},
        {16'hC400, 16'h0400, 16'h1234, 16'd1},
        {16'hC500, 16'h0400, 16'hF100, 16'd0},
        {16'hC680, 16'h0200, 16'h0020, 16'd2},
        {16'hC780, 16'h0500, 16'h1111, 16'd1},
        {16'hC480, 16'h0600, 16'hABCD, 16'd3},
        {16'hC0FF, 16'hFFFF, 16'h0000, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] instr_addr = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] ea;
    logic [15:0] acc_out;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int reads = 0;
    int dones = 0;
    int lat = 0;
    int wait_cnt = 0;
    int cycles = 0;
    logic [15:0] ovr_addr = '0;
    logic [15:0] ovr_data = '0;

    always #5 clk = ~clk;

    ea_load_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .instr_word(instr_word), .instr_addr(instr_addr),
        .xr1(XR1_V), .xr2(XR2_V), .xr3(XR3_V),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .ea(ea), .acc_out(acc_out), .done(done)
    );

    function automatic logic [15:0] mem_f(input logic [15:0] a);
        if (a == ovr_addr) return ovr_data;
        return {a[7:0], a[15:8]} ^ 16'h3C96;
    endfunction

    // Behavioural memory: ready after lat waiting cycles.
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end else if (wait_cnt >= lat) begin
            mem_ready <= 1'b1;
            mem_rdata <= mem_f(mem_addr);
            wait_cnt  <= 0;
        end else begin
            mem_ready <= 1'b0;
            wait_cnt  <= wait_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && mem_ready) reads <= reads + 1;
        if (done) dones <= dones + 1;
    end

    // Watchdog.
    initial begin
        wait (cycles >= 20000);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [7:0] d);
        return {{8{d[7]}}, d};
    endfunction

    function automatic logic [15:0] xr_of(input logic [1:0] t);
        return (t == 2'd1) ? XR1_V : (t == 2'd2) ? XR2_V : XR3_V;
    endfunction

    task automatic pulse_start(input logic [15:0] w, input logic [15:0] ia);
        @(negedge clk);
        instr_word = w;
        instr_addr = ia;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        bit ok;
        logic [15:0] w1, ia, w2, base, exp_ea;
        int exp_reads;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 acc in reset", acc_out, 16'h0);
        check("R1 ea in reset", ea, 16'h0);
        check("R1 done in reset", {15'b0, done}, 16'h0);
        check("R1 req in reset", {15'b0, mem_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after reset", acc_out, 16'h0);

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            w1 = VEC[v][63:48]; ia = VEC[v][47:32]; w2 = VEC[v][31:16];
            lat = int'(VEC[v][15:0]);
            ovr_addr = ia + 16'd1; ovr_data = w2;
            if (!w1[10]) begin
                base = (w1[9:8] == 2'd0) ? ia + 16'd1 : xr_of(w1[9:8]);
                exp_ea = base + sx(w1[7:0]);
                exp_reads = 1;
            end else begin
                exp_ea = (w1[9:8] == 2'd0) ? w2 : w2 + xr_of(w1[9:8]);
                exp_reads = 2;
                if (w1[7]) begin exp_ea = mem_f(exp_ea); exp_reads = 3; end
            end
            reads = 0;
            pulse_start(w1, ia);
            wait_done(ok);
            if (!ok) begin n_chk++; n_bad++; $display("FAIL R7 vec %0d: actual no done expected done", v); end
            check($sformatf("R3/R4/R5/R6 ea vec %0d", v), ea, exp_ea);
            check($sformatf("R7 acc vec %0d", v), acc_out, mem_f(exp_ea));
            @(negedge clk);
            check($sformatf("R5/R6 reads vec %0d", v), 16'(reads), 16'(exp_reads));
            check($sformatf("R7 single done vec %0d", v), {15'b0, done}, 16'h0);
        end

        // R2: foreign opcodes ignored
        begin
            logic [15:0] acc_before;
            acc_before = acc_out;
            reads = 0; dones = 0;
            pulse_start(16'hC805, 16'h0100);
            pulse_start(16'h4400, 16'h0100);
            repeat (10) @(negedge clk);
            check("R2 no reads", 16'(reads), 16'h0);
            check("R2 no done", 16'(dones), 16'h0);
            check("R2 acc kept", acc_out, acc_before);
        end

        // R9: start while busy ignored
        lat = 3;
        ovr_addr = 16'h0701; ovr_data = 16'h2222;
        reads = 0; dones = 0;
        pulse_start(16'hC400, 16'h0700);
        pulse_start(16'hC005, 16'h0100);
        wait_done(ok);
        check("R9 ea from first start", ea, 16'h2222);
        check("R9 acc from first start", acc_out, mem_f(16'h2222));
        repeat (8) @(negedge clk);
        check("R9 one completion", 16'(dones), 16'h1);
        check("R9 two reads only", 16'(reads), 16'h2);

        // R6: bit 7 in short format is displacement, not indirection
        lat = 0; reads = 0;
        pulse_start(16'hC080, 16'h0200);
        wait_done(ok);
        check("R6 short bit7 ea", ea, 16'h0181);
        @(negedge clk);
        check("R6 short one read", 16'(reads), 16'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule